// File: doc/BRIEF.md
# Opcode-Decoded Execute ALU

This block is the arithmetic unit of the execute stage of a five-stage, load/store pipeline. It takes the instruction word now in the execute stage and two 32-bit operands. It returns one 32-bit result. No separate control bus from the decoder is needed. The block reads the opcode fields of the instruction word itself and picks an operation from them. The operations are subtract, bitwise AND, bitwise OR, logical left shift, logical right shift, bitwise complement and an unsigned multiply of the operand low halves. Any other instruction word gets the sum of the two operands. That sum covers register adds, immediate adds and the address arithmetic of loads and stores.

The block is purely combinational and has no state. The result is valid in the same cycle as the inputs. The operation choice is a named selection, not a state machine. It has eight selections: `OP_ADD`, `OP_SUB`, `OP_AND`, `OP_OR`, `OP_SLL`, `OP_SRL`, `OP_CMPL` and `OP_MUL`. The "transitions" are the decode rules listed below. A barrel shifter built from log2(width) stages does both shift directions. A shift-and-add array forms the product.

Top module: `ex_alu`

## Requirements
- R1: When instruction bits 31..26 are 000000 and bits 5..0 are 100000, the result is op_a + op_b modulo 2^32.
- R2: Any instruction whose bits 31..26 are not 000000 gives op_a + op_b modulo 2^32. Examples are a load (100011), a store (101011) and an immediate add (001000).
- R3: Major 000000 with minor 100010 gives op_a - op_b modulo 2^32.
- R4: Major 000000 with minor 100100 gives op_a & op_b.
- R5: Major 000000 with minor 100101 gives op_a | op_b.
- R6: The minor codes for AND and OR act only with major 000000. With any other major, the same low six bits give the sum.
- R7: Major 000000 with minor 000000 shifts op_b left by the amount in instruction bits 10..6 and fills with zeros. An amount of 0 returns op_b unchanged.
- R8: Major 000000 with minor 000010 shifts op_b right by the amount in bits 10..6 and fills the vacated top bits with zeros.
- R9: Major 000000 with minor 001111 gives the bitwise inverse of op_a.
- R10: Major 000000 with minor 011000 gives the unsigned product of op_a[15:0] and op_b[15:0] as the full 32-bit result. Bits 31..16 of both operands have no effect.
- R11: Major 000000 with any minor code not listed above gives op_a + op_b.
- R12: The result follows the inputs combinationally, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word in the execute stage |
| op_a | input | 32 | First operand (the rs value) |
| op_b | input | 32 | Second operand (the rt value or the extended immediate) |
| result | output | 32 | Selected operation result |

## Verification
The bench targets the decode boundary first. It uses instruction words whose low six bits match the AND or OR code under a nonzero major. A decoder that ignores the major field would return a logical result there instead of the sum. Shift amounts of 0, 1, 4 and 31 are applied to operands with the top bit set. An arithmetic right shift or an off-by-one stage order would show up as wrong fill bits or a wrong position. The multiply uses all-ones low halves and operands with garbage in the upper halves. A signed product or a full-width product would differ in the top bits. Sums and differences that wrap past 2^32 check that no carry is lost and that no borrow leaks into the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;

    localparam logic [OPC_W-1:0] MAJ_REG  = 6'b000000;

    localparam logic [OPC_W-1:0] FN_ADD   = 6'b100000;
    localparam logic [OPC_W-1:0] FN_SUB   = 6'b100010;
    localparam logic [OPC_W-1:0] FN_AND   = 6'b100100;
    localparam logic [OPC_W-1:0] FN_OR    = 6'b100101;
    localparam logic [OPC_W-1:0] FN_SLL   = 6'b000000;
    localparam logic [OPC_W-1:0] FN_SRL   = 6'b000010;
    localparam logic [OPC_W-1:0] FN_CMPL  = 6'b001111;
    localparam logic [OPC_W-1:0] FN_MUL   = 6'b011000;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_SLL  = 3'd4,
        OP_SRL  = 3'd5,
        OP_CMPL = 3'd6,
        OP_MUL  = 3'd7
    } alu_op_e;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output alu_op_e            op
);

    logic [OPC_W-1:0] major;
    logic [OPC_W-1:0] minor;

    assign major = instr[INSTR_W-1 -: OPC_W];
    assign minor = instr[OPC_W-1:0];

    always_comb begin
        op = OP_ADD;
        if (major == MAJ_REG) begin
            unique case (minor)
                FN_SUB:  op = OP_SUB;
                FN_AND:  op = OP_AND;
                FN_OR:   op = OP_OR;
                FN_SLL:  op = OP_SLL;
                FN_SRL:  op = OP_SRL;
                FN_CMPL: op = OP_CMPL;
                FN_MUL:  op = OP_MUL;
                default: op = OP_ADD;
            endcase
        end
    end

    always_comb begin
        // R2
        if (major != MAJ_REG) begin
            nonreg_add_chk: assert (op == OP_ADD);
        end
        // R6
        if (op == OP_AND || op == OP_OR) begin
            logic_needs_reg_chk: assert (major == MAJ_REG);
        end
    end

endmodule

// File: rtl/alu_barrel_shift.sv
module alu_barrel_shift #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  dout
);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stg [0:AW];

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign rev_in[i]  = din[W-1-i];
            assign rev_out[i] = stg[AW][W-1-i];
        end
    endgenerate

    assign stg[0] = left ? rev_in : din;

    generate
        for (genvar s = 0; s < AW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stg[s+1] = amt[s] ? (stg[s] >> STEP) : stg[s];
        end
    endgenerate

    assign dout = left ? rev_out : stg[AW];

    always_comb begin
        // R7
        if (amt == '0) begin
            zero_shift_chk: assert (dout == din);
        end
        // R8
        if (!left && amt != '0) begin
            right_fill_chk: assert (dout[W-1] == 1'b0);
        end
        // R7
        if (left && amt != '0) begin
            left_fill_chk: assert (dout[0] == 1'b0);
        end
    end

endmodule

// File: rtl/alu_mul16.sv
module alu_mul16 #(
    parameter int HW = 16,
    localparam int PW = 2 * HW
) (
    input  logic [HW-1:0] x,
    input  logic [HW-1:0] y,
    output logic [PW-1:0] p
);

    logic [PW-1:0] pp [HW];

    generate
        for (genvar i = 0; i < HW; i++) begin : g_pp
            assign pp[i] = y[i] ? ({{HW{1'b0}}, x} << i) : '0;
        end
    endgenerate

    always_comb begin
        p = '0;
        for (int i = 0; i < HW; i++) begin
            p = p + pp[i];
        end
    end

    always_comb begin
        // R10
        if (y == HW'(1)) begin
            unit_mul_chk: assert (p == {{HW{1'b0}}, x});
        end
        // R10
        if (x == '0 || y == '0) begin
            zero_mul_chk: assert (p == '0);
        end
    end

endmodule

// File: rtl/ex_alu.sv
module ex_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int HALF = WIDTH / 2,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [WIDTH-1:0]   result
);

    localparam int SHAMT_LSB = 6;

    alu_op_e         op;
    logic [SHW-1:0]  shamt;
    logic [WIDTH-1:0] shift_out;
    logic [WIDTH-1:0] mul_out;
    logic [WIDTH-1:0] sum_out;
    logic [WIDTH-1:0] diff_out;

    assign shamt = instr[SHAMT_LSB +: SHW];

    alu_op_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    alu_barrel_shift #(.W(WIDTH), .AW(SHW)) u_shift (
        .din  (op_b),
        .amt  (shamt),
        .left (op == OP_SLL),
        .dout (shift_out)
    );

    alu_mul16 #(.HW(HALF)) u_mul (
        .x (op_a[HALF-1:0]),
        .y (op_b[HALF-1:0]),
        .p (mul_out)
    );

    assign sum_out  = op_a + op_b;
    assign diff_out = op_a - op_b;

    always_comb begin
        unique case (op)
            OP_SUB:  result = diff_out;
            OP_AND:  result = op_a & op_b;
            OP_OR:   result = op_a | op_b;
            OP_SLL:  result = shift_out;
            OP_SRL:  result = shift_out;
            OP_CMPL: result = ~op_a;
            OP_MUL:  result = mul_out;
            default: result = sum_out;
        endcase
    end

    always_comb begin
        // R3
        if (op == OP_SUB) begin
            sub_inverse_chk: assert (result + op_b == op_a);
        end
        // R9
        if (op == OP_CMPL) begin
            cmpl_xor_chk: assert ((result ^ op_a) == '1);
        end
        // R4
        if (op == OP_AND) begin
            and_subset_chk: assert ((result & ~op_a) == '0);
        end
        // R5
        if (op == OP_OR) begin
            or_superset_chk: assert ((op_a & ~result) == '0);
        end
        // R1
        if (op == OP_ADD) begin
            add_inverse_chk: assert (result - op_b == op_a);
        end
    end

endmodule

// File: tb/sim_ex_alu.sv
module sim_ex_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ex_alu u0 (
        .instr  (instr),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result)
    );

    function automatic logic [31:0] mk_r(input logic [5:0] fn, input logic [4:0] sh);
        return {6'b000000, 5'd3, 5'd4, 5'd5, sh, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] maj, input logic [15:0] imm);
        return {maj, 5'd1, 5'd2, imm};
    endfunction

    task automatic drive_check(input logic [31:0] i, input logic [31:0] a,
                               input logic [31:0] b, input logic [31:0] exp,
                               input string req);
        @(negedge clk);
        instr = i;
        op_a  = a;
        op_b  = b;
        #1;
        n_checks++;
        if (result !== exp) begin
            n_fails++;
            $display("FAIL %s: instr=%h a=%h b=%h actual=%h expected=%h",
                     req, i, a, b, result, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        n_checks++;
        if (result !== 32'h0) begin
            n_fails++;
            $display("FAIL R12 reset: actual=%h expected=%h", result, 32'h0);
        end
    endtask

    task automatic t_add;
        drive_check(mk_r(6'b100000, 5'd0), 32'd12, 32'd30, 32'd42, "R1");
        drive_check(mk_r(6'b100000, 5'd7), 32'hFFFF_FFFF, 32'd1, 32'h0, "R1 wrap");
    endtask

    task automatic t_nonreg;
        drive_check(mk_i(6'b100011, 16'h0010), 32'h0000_1000, 32'h10, 32'h0000_1010, "R2 load");
        drive_check(mk_i(6'b101011, 16'hFFFC), 32'h0000_1000, 32'hFFFF_FFFC, 32'h0000_0FFC, "R2 store");
        drive_check(mk_i(6'b001000, 16'h0005), 32'd100, 32'd5, 32'd105, "R2 addi");
        drive_check(mk_i(6'b001100, 16'h0024), 32'hF0F0_0000, 32'h0F0F_0024, 32'hFFFF_0024, "R6 and-code");
        drive_check(mk_i(6'b001101, 16'h0025), 32'h0000_0003, 32'h0000_0025, 32'h0000_0028, "R6 or-code");
    endtask

    task automatic t_sub;
        drive_check(mk_r(6'b100010, 5'd0), 32'd5, 32'd7, 32'hFFFF_FFFE, "R3 borrow");
        drive_check(mk_r(6'b100010, 5'd0), 32'd50, 32'd8, 32'd42, "R3");
    endtask

    task automatic t_logic;
        drive_check(mk_r(6'b100100, 5'd0), 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, "R4");
        drive_check(mk_r(6'b100101, 5'd0), 32'hF000_0001, 32'h0000_0F10, 32'hF000_0F11, "R5");
    endtask

    task automatic t_shift;
        drive_check(mk_r(6'b000000, 5'd0), 32'hDEAD_0000, 32'h8000_0001, 32'h8000_0001, "R7 amt0");
        drive_check(mk_r(6'b000000, 5'd1), 32'h0, 32'h8000_0001, 32'h0000_0002, "R7 amt1");
        drive_check(mk_r(6'b000000, 5'd31), 32'h0, 32'h0000_0003, 32'h8000_0000, "R7 amt31");
        drive_check(mk_r(6'b000010, 5'd4), 32'h0, 32'h8000_0000, 32'h0800_0000, "R8 amt4");
        drive_check(mk_r(6'b000010, 5'd31), 32'h0, 32'hFFFF_FFFF, 32'h0000_0001, "R8 amt31");
    endtask

    task automatic t_cmpl;
        drive_check(mk_r(6'b001111, 5'd0), 32'h1234_F00F, 32'hFFFF_FFFF, 32'hEDCB_0FF0, "R9");
    endtask

    task automatic t_mul;
        drive_check(mk_r(6'b011000, 5'd0), 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFE_0001, "R10 max");
        drive_check(mk_r(6'b011000, 5'd0), 32'hABCD_0003, 32'h1234_0005, 32'd15, "R10 upper ignored");
        drive_check(mk_r(6'b011000, 5'd0), 32'h0000_0100, 32'h0000_0300, 32'h0003_0000, "R10");
    endtask

    task automatic t_unlisted;
        drive_check(mk_r(6'b100111, 5'd0), 32'd9, 32'd11, 32'd20, "R11");
        drive_check(mk_r(6'b101010, 5'd0), 32'hFFFF_FFF0, 32'h20, 32'h10, "R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_nonreg();
        t_sub();
        t_logic();
        t_shift();
        t_cmpl();
        t_mul();
        t_unlisted();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule